// File: doc/BRIEF.md
# Operand/Result Handshake Computation Unit

This unit sits between an issue stage and an arithmetic unit that takes a variable number of cycles. A single-cycle issue pulse hands it an operation. The unit then collects each source operand through its own release/go handshake per port. It passes the operands to the arithmetic unit over valid/ready. Finally it returns each produced result through a second release/go handshake per output port. `busy_o` stays high from issue until the last write-back is accepted, so the unit never loses a result.

Some source ports may not need a read. Port A can be replaced by zero and port B by the latched immediate, and the issuer can mask any port for the whole operation. Output ports whose result is not valid are skipped and reported on the write-mask output. The last output port carries condition flags, and it is written only when flag recording was requested. A no-operation (kind code 0) still collects its unmasked operands. It never starts the arithmetic unit and never writes.

Both valid/ready links follow the usual rules. Valid may rise without waiting for ready. Once raised, valid and its data hold until the cycle in which ready is also high. The transfer happens on that edge. Back-pressure from either side only stretches the operation: the unit and the arithmetic unit can each stall for any number of cycles.

Top module: `comp_unit`

## Requirements
- R1: After an issue pulse in an idle cycle, `busy_o` is high from the next cycle. An issue pulse while busy is ignored and does not disturb the operation in flight.
- R2: The kind, invert, zero-A, immediate-valid, immediate value and flag-record fields are sampled only on the accepted issue edge. Later changes to these inputs have no effect on operands, on `alu_op_o`/`alu_inv_o`, or on results.
- R3: A source port that is requested raises `rd_rel_o[i]` in the cycle after issue. `src_i` for that port is captured on the edge where `rd_rel_o[i]` and `rd_go_i[i]` are both high. Go may come in the first release cycle or any later one, and ports complete in any order. The release is low in the cycle after its go.
- R4: While `rd_maskn_i[i]` is 1 (held by the issuer for the whole busy period), port i never raises its release and counts as satisfied. If the port is not substituted, it supplies operand value 0.
- R5: With zero-A set, port 0 is never requested and operand 0 is zero. With immediate-valid set, port 1 is never requested and operand 1 is the latched immediate, even if the port is masked.
- R6: `alu_in_valid_o` rises in the cycle after the last operand is captured or satisfied. It holds, with stable `alu_opnd_o` (port i at bits i*DW upward), until `alu_in_ready_i` is high.
- R7: `alu_out_ready_o` is high only while the unit waits for a result. On the valid-and-ready edge, `alu_res_i` (port j at bits j*DW upward) is registered onto `dest_o` and held there.
- R8: Output port j raises `wr_rel_o[j]` if `alu_ok_i[j]` was 1 at capture. The last port also needs flag recording. The release holds until `wr_go_i[j]` and is low in the cycle after it. While any write release is up, `wr_mask_o[j]` is 1 exactly for the skipped ports.
- R9: `busy_o` falls in the cycle after the last outstanding handshake (the final write go, or the final read go for a no-operation), and never earlier. While idle, no release is high.
- R10: Kind 0 (no-operation) never raises `alu_in_valid_o` or any write release. With all reads masked or substituted it holds `busy_o` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One-cycle operation issue pulse |
| op_kind_i | input | OPW | Operation kind, 0 is no-operation |
| op_inv_i | input | 1 | Invert-first-operand flag passed to the arithmetic unit |
| op_zero_a_i | input | 1 | Replace source port 0 by zero |
| op_imm_ok_i | input | 1 | Replace source port 1 by the immediate |
| op_imm_i | input | DW | Immediate value |
| op_rc_i | input | 1 | Record condition flags on the last output port |
| busy_o | output | 1 | Operation in flight |
| rd_maskn_i | input | NSRC | Per-port read mask, held while busy |
| rd_rel_o | output | NSRC | Per-port read release |
| rd_go_i | input | NSRC | Per-port read go |
| src_i | input | NSRC*DW | Source operand data, valid with go |
| alu_in_valid_o | output | 1 | Operands valid to the arithmetic unit |
| alu_in_ready_i | input | 1 | Arithmetic unit accepts operands |
| alu_op_o | output | OPW | Latched operation kind |
| alu_inv_o | output | 1 | Latched invert flag |
| alu_opnd_o | output | NSRC*DW | Collected operands |
| alu_out_valid_i | input | 1 | Result valid from the arithmetic unit |
| alu_out_ready_o | output | 1 | Unit ready to take the result |
| alu_res_i | input | NDST*DW | Result per output port |
| alu_ok_i | input | NDST | Per-port result validity |
| wr_rel_o | output | NDST | Per-port write release |
| wr_go_i | input | NDST | Per-port write go |
| wr_mask_o | output | NDST | Skipped output ports during write-back |
| dest_o | output | NDST*DW | Registered results |

## Verification
Every output is due a fixed number of edges after its cause. Releases appear one cycle after issue, and a release falls one cycle after its go. Operands reach the arithmetic unit one cycle after the last capture. A result is on `dest_o` one cycle after the output handshake, and `busy_o` falls one cycle after the last go. The bench drives every input at the falling edge and reads every output there. It records the iteration of each go it gives, then demands the exact cycle for the release drop and for the fall of `busy_o`. The sweep covers every read-mask pattern, substitution combination, flag-record setting and several delay orderings. Expected operands and results come from bench arithmetic.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_EXEC  = 3'd2,
    PH_WAIT  = 3'd3,
    PH_WRITE = 3'd4
  } phase_t;
endpackage

// File: rtl/cu_src_port.sv
module cu_src_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic          sub_in,
  input  logic [DW-1:0] sub_val,
  input  logic          maskn,
  input  logic          go,
  input  logic [DW-1:0] din,
  output logic          rel,
  output logic          done,
  output logic [DW-1:0] opnd
);
  logic          got_q;
  logic          sub_q;
  logic [DW-1:0] val_q;

  assign rel  = active & ~sub_q & ~maskn & ~got_q;
  assign done = got_q | sub_q | maskn | (rel & go);
  assign opnd = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= 1'b0;
      sub_q <= 1'b0;
      val_q <= '0;
    end else if (start) begin
      got_q <= 1'b0;
      sub_q <= sub_in;
      val_q <= sub_in ? sub_val : '0;
    end else if (rel && go) begin
      got_q <= 1'b1;
      val_q <= din;
    end
  end

  AST_RD_REL_DROP: assert property (@(posedge clk) disable iff (!rst_n) rel && go |=> !rel); // R3
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) rel && go |=> opnd == $past(din)); // R3
endmodule

// File: rtl/cu_dst_port.sv
module cu_dst_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          want,
  input  logic [DW-1:0] din,
  input  logic          go,
  output logic          rel,
  output logic [DW-1:0] dout
);
  logic          pend_q;
  logic [DW-1:0] data_q;

  assign rel  = pend_q;
  assign dout = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      pend_q <= want;
      data_q <= din;
    end else if (pend_q && go) begin
      pend_q <= 1'b0;
    end
  end

  AST_WR_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rel && !go |=> rel); // R8
  AST_WR_REL_DROP: assert property (@(posedge clk) disable iff (!rst_n) rel && go |=> !rel); // R8
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rel |=> $stable(dout)); // R7
endmodule

// File: rtl/cu_ctrl.sv
module cu_ctrl
  import cu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   issue,
  input  logic   all_read,
  input  logic   is_nop,
  input  logic   alu_in_ready,
  input  logic   alu_out_valid,
  input  logic   wr_left,
  output phase_t phase,
  output logic   start,
  output logic   load,
  output logic   alu_in_valid,
  output logic   alu_out_ready,
  output logic   busy
);
  phase_t nxt;

  assign start         = issue && (phase == PH_IDLE);
  assign load          = (phase == PH_WAIT) && alu_out_valid;
  assign alu_in_valid  = (phase == PH_EXEC);
  assign alu_out_ready = (phase == PH_WAIT);
  assign busy          = (phase != PH_IDLE);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:  if (issue) nxt = PH_READ;
      PH_READ:  if (all_read) nxt = is_nop ? PH_IDLE : PH_EXEC;
      PH_EXEC:  if (alu_in_ready) nxt = PH_WAIT;
      PH_WAIT:  if (alu_out_valid) nxt = PH_WRITE;
      PH_WRITE: if (!wr_left) nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  AST_ISSUE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_IDLE) && issue |=> busy); // R1
  AST_ISSUE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {PH_EXEC, PH_WAIT, PH_WRITE}) && issue |=> phase != PH_READ); // R1
endmodule

// File: rtl/comp_unit.sv
module comp_unit
  import cu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NSRC = 2,
  parameter int NDST = 2,
  parameter int OPW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [OPW-1:0]    op_kind_i,
  input  logic              op_inv_i,
  input  logic              op_zero_a_i,
  input  logic              op_imm_ok_i,
  input  logic [DW-1:0]     op_imm_i,
  input  logic              op_rc_i,
  output logic              busy_o,
  input  logic [NSRC-1:0]   rd_maskn_i,
  output logic [NSRC-1:0]   rd_rel_o,
  input  logic [NSRC-1:0]   rd_go_i,
  input  logic [NSRC*DW-1:0] src_i,
  output logic              alu_in_valid_o,
  input  logic              alu_in_ready_i,
  output logic [OPW-1:0]    alu_op_o,
  output logic              alu_inv_o,
  output logic [NSRC*DW-1:0] alu_opnd_o,
  input  logic              alu_out_valid_i,
  output logic              alu_out_ready_o,
  input  logic [NDST*DW-1:0] alu_res_i,
  input  logic [NDST-1:0]   alu_ok_i,
  output logic [NDST-1:0]   wr_rel_o,
  input  logic [NDST-1:0]   wr_go_i,
  output logic [NDST-1:0]   wr_mask_o,
  output logic [NDST*DW-1:0] dest_o
);
  localparam logic [OPW-1:0] KIND_NOP = '0;
  localparam int FLAG_PORT = NDST - 1;

  phase_t phase;
  logic   start, load, all_read, wr_left;

  logic [OPW-1:0] kind_q;
  logic           inv_q, rc_q;
  logic [NDST-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      inv_q  <= 1'b0;
      rc_q   <= 1'b0;
    end else if (start) begin
      kind_q <= op_kind_i;
      inv_q  <= op_inv_i;
      rc_q   <= op_rc_i;
    end
  end

  logic [NSRC-1:0]         src_done;
  logic [NSRC-1:0]         sub_en;
  logic [NSRC-1:0][DW-1:0] sub_val;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == 0) begin : g_zero
      assign sub_en[g]  = op_zero_a_i;
      assign sub_val[g] = '0;
    end else if (g == 1) begin : g_imm
      assign sub_en[g]  = op_imm_ok_i;
      assign sub_val[g] = op_imm_i;
    end else begin : g_plain
      assign sub_en[g]  = 1'b0;
      assign sub_val[g] = '0;
    end

    cu_src_port #(.DW(DW)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .active  (phase == PH_READ),
      .sub_in  (sub_en[g]),
      .sub_val (sub_val[g]),
      .maskn   (rd_maskn_i[g]),
      .go      (rd_go_i[g]),
      .din     (src_i[g*DW +: DW]),
      .rel     (rd_rel_o[g]),
      .done    (src_done[g]),
      .opnd    (alu_opnd_o[g*DW +: DW])
    );
  end

  assign all_read = &src_done;

  logic [NDST-1:0] want;

  for (genvar j = 0; j < NDST; j++) begin : g_dst
    if (j == FLAG_PORT) begin : g_flag
      assign want[j] = alu_ok_i[j] & rc_q;
    end else begin : g_data
      assign want[j] = alu_ok_i[j];
    end

    cu_dst_port #(.DW(DW)) u_dst (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .want  (want[j]),
      .din   (alu_res_i[j*DW +: DW]),
      .go    (wr_go_i[j]),
      .rel   (wr_rel_o[j]),
      .dout  (dest_o[j*DW +: DW])
    );
  end

  assign wr_left = |(wr_rel_o & ~wr_go_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= ~want;
  end

  assign wr_mask_o = (phase == PH_WRITE) ? mask_q : '0;
  assign alu_op_o  = kind_q;
  assign alu_inv_o = inv_q;

  cu_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue         (issue_i),
    .all_read      (all_read),
    .is_nop        (kind_q == KIND_NOP),
    .alu_in_ready  (alu_in_ready_i),
    .alu_out_valid (alu_out_valid_i),
    .wr_left       (wr_left),
    .phase         (phase),
    .start         (start),
    .load          (load),
    .alu_in_valid  (alu_in_valid_o),
    .alu_out_ready (alu_out_ready_o),
    .busy          (busy_o)
  );

  AST_ALU_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    alu_in_valid_o && !alu_in_ready_i |=> alu_in_valid_o && $stable(alu_opnd_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (rd_rel_o == '0) && (wr_rel_o == '0)); // R9
  AST_WR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    |(wr_rel_o & ~wr_go_i) |=> busy_o); // R9
  AST_NOP_NO_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (alu_op_o == KIND_NOP) |-> !alu_in_valid_o && (wr_rel_o == '0)); // R10
endmodule

// File: tb/comp_unit_tb_top.sv
`timescale 1ns/1ps
module comp_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        issue = 0, inv = 0, za = 0, im = 0, rc = 0;
  logic [2:0]  kind = 0;
  logic [15:0] imm = 0;
  logic [1:0]  rdmaskn = 0, rd_go = 0, wr_go = 0, alu_ok = 2'b11;
  logic [31:0] src = 0, alu_res = 0;
  logic        alu_in_ready = 0, alu_out_valid = 0;

  logic        busy, alu_in_valid, alu_inv, alu_out_ready;
  logic [1:0]  rd_rel, wr_rel, wr_mask;
  logic [2:0]  alu_op;
  logic [31:0] alu_opnd, dest;

  int total = 0;
  int bad = 0;

  comp_unit #(.DW(16), .NSRC(2), .NDST(2), .OPW(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_kind_i(kind), .op_inv_i(inv),
    .op_zero_a_i(za), .op_imm_ok_i(im), .op_imm_i(imm), .op_rc_i(rc), .busy_o(busy),
    .rd_maskn_i(rdmaskn), .rd_rel_o(rd_rel), .rd_go_i(rd_go), .src_i(src),
    .alu_in_valid_o(alu_in_valid), .alu_in_ready_i(alu_in_ready), .alu_op_o(alu_op),
    .alu_inv_o(alu_inv), .alu_opnd_o(alu_opnd), .alu_out_valid_i(alu_out_valid),
    .alu_out_ready_o(alu_out_ready), .alu_res_i(alu_res), .alu_ok_i(alu_ok),
    .wr_rel_o(wr_rel), .wr_go_i(wr_go), .wr_mask_o(wr_mask), .dest_o(dest)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] calc(input logic [2:0] kd, input logic iv, input logic [15:0] x, input logic [15:0] y);
    case (kd)
      3'd1:    calc = (iv ? ~x : x) + y;
      3'd2:    calc = x - y;
      3'd3:    calc = x & y;
      default: calc = 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] flags(input logic [15:0] r);
    if ($signed(r) > 0)      flags = 16'd4;
    else if ($signed(r) < 0) flags = 16'd2;
    else                     flags = 16'd1;
  endfunction

  task automatic run_op(input int k, input logic [1:0] rdm, input logic z, input logic iok,
                        input logic r, input int d);
    logic [2:0]  kd;
    logic [15:0] a, b, iv16, ea, eb, eres, ecr, ga, gb;
    logic        ivf, poke, acc, odone, ohs;
    logic [1:0]  req, wexp, rsv, wsv, emask;
    int rcnt[2], wcnt[2], rdly[2], wdly[2];
    int acnt, ocnt, it, last;
    kd   = 3'(k % 4);
    ivf  = (k % 8) >= 4;
    a    = 16'(k * 4099 + 123);
    b    = (k % 3 == 0) ? a : 16'(k * 77 + 9);
    iv16 = (k % 4 == 0) ? a : 16'(k * 13 + 1);
    ea   = (z || rdm[0]) ? 16'h0 : a;
    eb   = iok ? iv16 : (rdm[1] ? 16'h0 : b);
    eres = calc(kd, ivf, ea, eb);
    ecr  = flags(eres);
    req  = {~iok & ~rdm[1], ~z & ~rdm[0]};
    wexp = (kd == 3'd0) ? 2'b00 : {r, 1'b1};
    emask = ~wexp;
    poke = (k % 5 == 1) && (kd != 3'd0);
    rdly[0] = d; rdly[1] = (d + 2) % 3; wdly[0] = 2 - d; wdly[1] = d;
    rcnt[0] = 0; rcnt[1] = 0; wcnt[0] = 0; wcnt[1] = 0;
    acnt = 0; ocnt = 0; acc = 0; odone = 0; ohs = 0; rsv = 0; wsv = 0; last = 0;
    ga = 0; gb = 0;

    @(negedge clk);
    chk(!busy, "R9 idle before issue", 32'(busy), 32'd0);
    kind = kd; inv = ivf; za = z; im = iok; rc = r; imm = iv16; rdmaskn = rdm; issue = 1;
    @(negedge clk);
    issue = 0;
    kind = ~kd; inv = ~ivf; za = ~z; im = ~iok; rc = ~r; imm = ~iv16;
    it = 0;
    while (it < 300) begin
      if (it == 0) chk(busy, "R1 busy after issue", 32'(busy), 32'd1);
      if (!busy) begin
        chk(it == last + 1, "R9 busy drop cycle", 32'(it), 32'(last + 1));
        break;
      end
      if (poke && it == 1) begin issue = 1; kind = 3'd3; end
      if (poke && it == 2) issue = 0;
      for (int p = 0; p < 2; p++) begin
        if (rd_go[p]) begin
          rd_go[p] = 0;
          src[p*16 +: 16] = 16'h0;
          chk(!rd_rel[p], "R3 read release clears", 32'(rd_rel[p]), 32'd0);
        end else if (rd_rel[p]) begin
          if (!req[p] || rsv[p]) chk(0, "R4 R5 unexpected read release", 32'(p), 32'(req[p]));
          else if (rcnt[p] >= rdly[p]) begin
            rd_go[p] = 1;
            src[p*16 +: 16] = (p == 0) ? a : b;
            rsv[p] = 1;
            last = it;
          end else rcnt[p]++;
        end
      end
      if (alu_in_ready) alu_in_ready = 0;
      else if (alu_in_valid && !acc) begin
        if (kd == 3'd0) chk(0, "R10 nop started alu", 32'(alu_in_valid), 32'd0);
        else if (acnt >= d) begin
          alu_in_ready = 1;
          acc = 1;
          ga = alu_opnd[15:0];
          gb = alu_opnd[31:16];
          chk(ga == ea, "R4 R5 R6 operand A", 32'(ga), 32'(ea));
          chk(gb == eb, "R4 R5 R6 operand B", 32'(gb), 32'(eb));
          chk(alu_op == kd && alu_inv == ivf, "R2 latched fields", {28'h0, alu_inv, alu_op}, {28'h0, ivf, kd});
        end else acnt++;
      end
      if (acc && !odone) begin
        if (alu_out_valid) begin
          if (ohs) begin alu_out_valid = 0; odone = 1; end
          else if (alu_out_ready) ohs = 1;
        end else if (ocnt >= d) begin
          alu_out_valid = 1;
          alu_res[15:0]  = calc(alu_op, alu_inv, ga, gb);
          alu_res[31:16] = flags(alu_res[15:0]);
          ohs = alu_out_ready;
        end else ocnt++;
      end
      for (int q = 0; q < 2; q++) begin
        if (wr_go[q]) begin
          wr_go[q] = 0;
          chk(!wr_rel[q], "R8 write release clears", 32'(wr_rel[q]), 32'd0);
        end else if (wr_rel[q]) begin
          chk(wr_mask == emask, "R8 write mask", 32'(wr_mask), 32'(emask));
          if (!wexp[q] || wsv[q]) chk(0, "R8 R10 unexpected write release", 32'(q), 32'(wexp[q]));
          else if (wcnt[q] >= wdly[q]) begin
            wr_go[q] = 1;
            wsv[q] = 1;
            last = it;
            if (q == 0) chk(dest[15:0] == eres, "R7 R8 result data", 32'(dest[15:0]), 32'(eres));
            else        chk(dest[31:16] == ecr, "R7 R8 flag data", 32'(dest[31:16]), 32'(ecr));
          end else wcnt[q]++;
        end
      end
      it++;
      @(negedge clk);
    end
    if (it >= 300) chk(0, "R9 operation hung", 32'(it), 32'd300);
    chk(rsv == req, "R3 R4 R5 reads served", 32'(rsv), 32'(req));
    chk(wsv == wexp, "R8 R10 writes served", 32'(wsv), 32'(wexp));
    chk(acc == (kd != 3'd0), "R10 alu use", 32'(acc), 32'(kd != 3'd0));
    chk(rd_rel == 2'b00 && wr_rel == 2'b00, "R9 idle releases", {28'h0, wr_rel, rd_rel}, 32'd0);
    issue = 0; rdmaskn = 0; rd_go = 0; wr_go = 0; alu_in_ready = 0; alu_out_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    chk(!busy && rd_rel == 2'b00 && wr_rel == 2'b00 && !alu_in_valid, "R9 reset state",
        {27'h0, alu_in_valid, wr_rel, rd_rel} | 32'(busy), 32'd0);
    rst_n = 1;
    for (int m = 0; m < 4; m++)
      for (int zz = 0; zz < 2; zz++)
        for (int ii = 0; ii < 2; ii++)
          for (int rr = 0; rr < 2; rr++)
            for (int dd = 0; dd < 3; dd++) begin
              run_op(k, 2'(m), zz[0], ii[0], rr[0], dd);
              k++;
            end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule